// File: doc/BRIEF.md
# DRAM Refresh and Power-Up Sequencer

This block keeps an asynchronous DRAM alive and brings it up correctly after reset. After reset it waits a programmable pause, counted in clock cycles, before it starts any memory cycle. It then runs a fixed number of dummy refresh cycles, and only then raises a ready flag that lets normal accesses begin. From that point an interval counter creates one refresh obligation per programmed interval, so that every row is visited within the retention window.

Refresh cycles are shared with the access controller through a request/grant handshake. The sequencer raises a request whenever it owes a refresh and is idle. Once it sees the grant it drives the row and column strobes itself and marks the last cycle with a one-cycle done pulse. Obligations that cannot be served at once, for example during a long page burst, are kept in a small saturating counter so that they are not lost. A parameter selects the refresh style. In the CAS-first style the device supplies the row from its internal counter. In the row-strobe-only style the sequencer drives a row address from its own wrapping counter.

Top module: `dram_refresh_seq`

## Requirements
- R1: While reset is held, `mem_ready`, `ref_req` and `ref_done` are 0 and both `ras_n` and `cas_n` are 1.
- R2: `ref_req` stays 0 for the first PAUSE_CYC clock edges after reset is released and is first seen high after edge PAUSE_CYC.
- R3: `mem_ready` rises on the edge that ends the DUMMY_CNT-th refresh (8 by default), and never earlier. Once high it stays high until reset.
- R4: In CAS-first mode (RAS_ONLY=0) each refresh holds `cas_n` low and `ras_n` high for T_LEAD cycles. It then holds both low for T_ACT cycles, then both high for T_PRE cycles. `ref_done` is 1 in the last of those precharge cycles.
- R5: In row-strobe-only mode (RAS_ONLY=1) each refresh holds `ras_n` low for T_ACT cycles and then high for T_PRE cycles. `cas_n` stays 1 for the whole refresh, and `row_addr` is stable while `ras_n` is low.
- R6: In row-strobe-only mode the row on `row_addr` during the n-th refresh (counted from 0 after reset, dummies included) is n mod 2^ROW_W, so it wraps from 2047 to 0 when ROW_W=11. In CAS-first mode `row_addr` is always 0.
- R7: After `mem_ready` rises on edge E, one refresh is owed on each edge E + m*INTERVAL_CYC (m >= 1). If the grant is held high, the done pulse of that refresh is seen after edge E + m*INTERVAL_CYC + L, where L is the cycle length (T_LEAD+T_ACT+T_PRE in CAS-first mode, T_ACT+T_PRE otherwise).
- R8: Owed refreshes accumulate up to PEND_MAX and no further. When the grant returns after a long wait, exactly PEND_MAX refreshes are run back to back, each starting one idle cycle after the previous done.
- R9: No refresh starts without `ref_gnt`. While no refresh is running, both strobes are 1 and `ref_done` is 0.
- R10: `ref_done` lasts one cycle. `ref_req` is 0 whenever a refresh is in progress, so while `ref_req` is 1 both strobes are 1.
- R11: Elaboration fails unless T_ACT+T_PRE covers the minimum random cycle T_RC_CYC, INTERVAL_CYC * 2^ROW_W fits within RETAIN_CYC, and T_LEAD >= 1 in CAS-first mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_gnt | input | 1 | Bus grant from the access controller; a refresh may start while it is high |
| ref_req | output | 1 | Refresh owed and sequencer idle |
| ref_done | output | 1 | One-cycle pulse in the final precharge cycle of a refresh |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| row_addr | output | ROW_W | Refresh row in row-strobe-only mode while a refresh runs, else 0 |
| mem_ready | output | 1 | Power-up pause and dummy refreshes complete |

## Verification
Two instances, one per refresh style, are run side by side for more than 2048 refreshes. This checks the row counter across its wrap; an off-by-one in the wrap or a counter that skips the dummy cycles would show a wrong row on the first compare after the fault. The first request is timed against the pause length, and the rise of ready is tied to the count of dummy done pulses. A pause or dummy count that is off by one, or a ready flag that rises early, is caught on that single edge. The grant is withheld across six intervals and the burst that follows is counted. A debt counter that does not saturate, or one that drops requests, would deliver more or fewer than PEND_MAX refreshes. The timing of every later done pulse against the interval grid would also shift.

// File: rtl/dram_ref_pkg.sv
package dram_ref_pkg;

   typedef enum logic [1:0] {
      ST_IDLE,
      ST_LEAD,
      ST_STROBE,
      ST_PRECH
   } strobe_st_t;

   typedef enum logic [1:0] {
      PH_PAUSE,
      PH_DUMMY,
      PH_RUN
   } init_phase_t;

   function automatic int max3(input int a, input int b, input int c);
      int m;
      m = (a > b) ? a : b;
      return (m > c) ? m : c;
   endfunction

endpackage

// File: rtl/ref_init_seq.sv
module ref_init_seq
   import dram_ref_pkg::*;
#(
   parameter int PAUSE_CYC = 25001,
   parameter int DUMMY_CNT = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic ref_done,
   output logic dummy_owed,
   output logic ready
);

   localparam int PW = $clog2(PAUSE_CYC + 1);
   localparam int DW = $clog2(DUMMY_CNT + 1);

   generate
      if (PAUSE_CYC < 1) begin : g_bad_pause
         $error("PAUSE_CYC must be at least 1");
      end
      if (DUMMY_CNT < 1) begin : g_bad_dummy
         $error("DUMMY_CNT must be at least 1");
      end
   endgenerate

   init_phase_t     phase;
   logic [PW-1:0]   pause_cnt;
   logic [DW-1:0]   dummy_left;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase      <= PH_PAUSE;
         pause_cnt  <= '0;
         dummy_left <= DW'(DUMMY_CNT);
      end else begin
         unique case (phase)
            PH_PAUSE: begin
               if (pause_cnt == PW'(PAUSE_CYC - 1)) begin
                  phase <= PH_DUMMY;
               end else begin
                  pause_cnt <= pause_cnt + 1'b1;
               end
            end
            PH_DUMMY: begin
               if (ref_done) begin
                  dummy_left <= dummy_left - 1'b1;
                  if (dummy_left == DW'(1)) begin
                     phase <= PH_RUN;
                  end
               end
            end
            default: ;
         endcase
      end
   end

   assign dummy_owed = (phase == PH_DUMMY);
   assign ready      = (phase == PH_RUN);

   // R3
   ready_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ready |=> ready);

   // R2
   pause_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == PH_PAUSE) |-> !ref_done);

endmodule

// File: rtl/ref_pacer.sv
module ref_pacer #(
   parameter int INTERVAL_CYC = 1950,
   parameter int PEND_MAX     = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic enable,
   input  logic served,
   output logic owed
);

   localparam int IW = $clog2(INTERVAL_CYC);
   localparam int PW = $clog2(PEND_MAX + 1);

   generate
      if (INTERVAL_CYC < 2) begin : g_bad_ivl
         $error("INTERVAL_CYC must be at least 2");
      end
      if (PEND_MAX < 1) begin : g_bad_pend
         $error("PEND_MAX must be at least 1");
      end
   endgenerate

   logic [IW-1:0] ivl;
   logic [PW-1:0] pend;
   logic          tick;

   assign tick = enable && (ivl == IW'(INTERVAL_CYC - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ivl <= '0;
      end else if (enable) begin
         ivl <= tick ? '0 : ivl + 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend <= '0;
      end else begin
         unique case ({tick, served})
            2'b10: if (pend != PW'(PEND_MAX)) pend <= pend + 1'b1;
            2'b01: pend <= pend - 1'b1;
            default: ;
         endcase
      end
   end

   assign owed = (pend != '0);

   // R8
   pend_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pend <= PW'(PEND_MAX));

   // R7
   served_has_debt_chk: assert property (@(posedge clk) disable iff (!rst_n)
      served |-> (pend != '0));

endmodule

// File: rtl/ref_strobe_fsm.sv
module ref_strobe_fsm
   import dram_ref_pkg::*;
#(
   parameter bit RAS_ONLY = 1'b0,
   parameter int T_LEAD   = 1,
   parameter int T_ACT    = 6,
   parameter int T_PRE    = 5
) (
   input  logic clk,
   input  logic rst_n,
   input  logic owed,
   input  logic gnt,
   output logic ras_n,
   output logic cas_n,
   output logic busy,
   output logic done
);

   localparam int MAXT     = max3(T_LEAD, T_ACT, T_PRE);
   localparam int CW       = $clog2(MAXT + 1);
   localparam bit USE_LEAD = !RAS_ONLY;

   generate
      if (T_ACT < 1 || T_PRE < 1) begin : g_bad_phase
         $error("T_ACT and T_PRE must be at least 1");
      end
      if (USE_LEAD && T_LEAD < 1) begin : g_bad_lead
         $error("CAS-first refresh needs T_LEAD of at least 1");
      end
   endgenerate

   strobe_st_t    state;
   logic [CW-1:0] cnt;
   logic          start;

   assign start = (state == ST_IDLE) && owed && gnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state <= ST_IDLE;
         cnt   <= '0;
      end else begin
         unique case (state)
            ST_IDLE: begin
               if (start) begin
                  if (USE_LEAD) begin
                     state <= ST_LEAD;
                     cnt   <= CW'(T_LEAD - 1);
                  end else begin
                     state <= ST_STROBE;
                     cnt   <= CW'(T_ACT - 1);
                  end
               end
            end
            ST_LEAD: begin
               if (cnt == '0) begin
                  state <= ST_STROBE;
                  cnt   <= CW'(T_ACT - 1);
               end else begin
                  cnt <= cnt - 1'b1;
               end
            end
            ST_STROBE: begin
               if (cnt == '0) begin
                  state <= ST_PRECH;
                  cnt   <= CW'(T_PRE - 1);
               end else begin
                  cnt <= cnt - 1'b1;
               end
            end
            default: begin
               if (cnt == '0) begin
                  state <= ST_IDLE;
               end else begin
                  cnt <= cnt - 1'b1;
               end
            end
         endcase
      end
   end

   assign ras_n = (state != ST_STROBE);
   assign busy  = (state != ST_IDLE);
   assign done  = (state == ST_PRECH) && (cnt == '0);

   generate
      if (RAS_ONLY) begin : g_row_only
         assign cas_n = 1'b1;
      end else begin : g_cas_first
         assign cas_n = !((state == ST_LEAD) || (state == ST_STROBE));

         // R4
         cas_lead_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(ras_n) |-> (!cas_n && $past(!cas_n)));
      end
   endgenerate

   // R9
   idle_without_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((state == ST_IDLE) && !gnt) |=> (state == ST_IDLE));

   // R10
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R4
   precharge_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (ras_n && cas_n));

endmodule

// File: rtl/ref_row_ctr.sv
module ref_row_ctr #(
   parameter int ROW_W = 11
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             step,
   output logic [ROW_W-1:0] row
);

   generate
      if (ROW_W < 1) begin : g_bad_row
         $error("ROW_W must be at least 1");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         row <= '0;
      end else if (step) begin
         row <= row + 1'b1;
      end
   end

endmodule

// File: rtl/dram_refresh_seq.sv
module dram_refresh_seq #(
   parameter bit RAS_ONLY     = 1'b0,
   parameter int ROW_W        = 11,
   parameter int PAUSE_CYC    = 25001,
   parameter int DUMMY_CNT    = 8,
   parameter int INTERVAL_CYC = 1950,
   parameter int PEND_MAX     = 4,
   parameter int RETAIN_CYC   = 4000000,
   parameter int T_LEAD       = 1,
   parameter int T_ACT        = 6,
   parameter int T_PRE        = 5,
   parameter int T_RC_CYC     = 11
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ref_gnt,
   output logic             ref_req,
   output logic             ref_done,
   output logic             ras_n,
   output logic             cas_n,
   output logic [ROW_W-1:0] row_addr,
   output logic             mem_ready
);

   localparam longint SWEEP_CYC = longint'(INTERVAL_CYC) * (longint'(1) << ROW_W);

   generate
      // R11
      if (T_ACT + T_PRE < T_RC_CYC) begin : g_bad_trc
         $error("strobe and precharge time shorter than the random cycle");
      end
      if (SWEEP_CYC > longint'(RETAIN_CYC)) begin : g_bad_retain
         $error("refresh interval too long to cover all rows in the retention time");
      end
   endgenerate

   logic dummy_owed;
   logic pace_owed;
   logic owed;
   logic busy;
   logic done;

   ref_init_seq #(
      .PAUSE_CYC (PAUSE_CYC),
      .DUMMY_CNT (DUMMY_CNT)
   ) u_init (
      .clk        (clk),
      .rst_n      (rst_n),
      .ref_done   (done),
      .dummy_owed (dummy_owed),
      .ready      (mem_ready)
   );

   ref_pacer #(
      .INTERVAL_CYC (INTERVAL_CYC),
      .PEND_MAX     (PEND_MAX)
   ) u_pacer (
      .clk    (clk),
      .rst_n  (rst_n),
      .enable (mem_ready),
      .served (done && mem_ready),
      .owed   (pace_owed)
   );

   assign owed = dummy_owed || (mem_ready && pace_owed);

   ref_strobe_fsm #(
      .RAS_ONLY (RAS_ONLY),
      .T_LEAD   (T_LEAD),
      .T_ACT    (T_ACT),
      .T_PRE    (T_PRE)
   ) u_strobe (
      .clk   (clk),
      .rst_n (rst_n),
      .owed  (owed),
      .gnt   (ref_gnt),
      .ras_n (ras_n),
      .cas_n (cas_n),
      .busy  (busy),
      .done  (done)
   );

   assign ref_req  = owed && !busy;
   assign ref_done = done;

   generate
      if (RAS_ONLY) begin : g_row_drive
         logic [ROW_W-1:0] row;

         ref_row_ctr #(
            .ROW_W (ROW_W)
         ) u_row (
            .clk   (clk),
            .rst_n (rst_n),
            .step  (done),
            .row   (row)
         );

         assign row_addr = busy ? row : '0;

         // R5
         row_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (!ras_n && $past(!ras_n)) |-> $stable(row_addr));
      end else begin : g_row_none
         assign row_addr = '0;
      end
   endgenerate

   // R10
   req_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ref_req |-> (ras_n && cas_n));

   // R3
   ready_after_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(mem_ready) |-> $past(ref_done));

endmodule

// File: tb/test_dram_refresh_seq.sv
module test_dram_refresh_seq;

   localparam int ROW_W   = 11;
   localparam int PAUSE   = 20;
   localparam int DUMMY   = 8;
   localparam int IVL     = 40;
   localparam int PMAX    = 3;
   localparam int T_LEAD  = 1;
   localparam int T_ACT   = 3;
   localparam int T_PRE   = 2;
   localparam int ROWS    = 1 << ROW_W;
   localparam int TARGET  = DUMMY + ROWS + 2;

   logic clk = 1'b0;
   logic rst_n;
   always #4 clk = ~clk;

   logic             gnt   [2];
   logic             req   [2];
   logic             done  [2];
   logic             ras   [2];
   logic             cas   [2];
   logic             rdy   [2];
   logic [ROW_W-1:0] row   [2];

   dram_refresh_seq #(
      .RAS_ONLY (1'b0), .ROW_W (ROW_W), .PAUSE_CYC (PAUSE), .DUMMY_CNT (DUMMY),
      .INTERVAL_CYC (IVL), .PEND_MAX (PMAX), .RETAIN_CYC (100000),
      .T_LEAD (T_LEAD), .T_ACT (T_ACT), .T_PRE (T_PRE), .T_RC_CYC (5)
   ) i_dram_refresh_seq (
      .clk (clk), .rst_n (rst_n), .ref_gnt (gnt[0]), .ref_req (req[0]),
      .ref_done (done[0]), .ras_n (ras[0]), .cas_n (cas[0]),
      .row_addr (row[0]), .mem_ready (rdy[0])
   );

   dram_refresh_seq #(
      .RAS_ONLY (1'b1), .ROW_W (ROW_W), .PAUSE_CYC (PAUSE), .DUMMY_CNT (DUMMY),
      .INTERVAL_CYC (IVL), .PEND_MAX (PMAX), .RETAIN_CYC (100000),
      .T_LEAD (T_LEAD), .T_ACT (T_ACT), .T_PRE (T_PRE), .T_RC_CYC (5)
   ) i_dram_refresh_seq_ro (
      .clk (clk), .rst_n (rst_n), .ref_gnt (gnt[1]), .ref_req (req[1]),
      .ref_done (done[1]), .ras_n (ras[1]), .cas_n (cas[1]),
      .row_addr (row[1]), .mem_ready (rdy[1])
   );

   int checks = 0;
   int fails  = 0;

   int since_rst [2];
   int k         [2];
   bit req_seen  [2];
   bit rdy_seen  [2];
   int dummies   [2];
   int ref_idx   [2];
   int n_ras     [2];
   int n_lead    [2];
   int n_cas_act [2];
   int n_bad     [2];
   int burst     [2];

   task automatic chk(input bit ok, input string tag, input int d,
                      input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s dut%0d actual %0d expected %0d", tag, d, act, exp);
      end
   endtask

   task automatic monitor(input int d);
      int len;
      bit in_burst;
      len = (d == 0) ? (T_LEAD + T_ACT + T_PRE) : (T_ACT + T_PRE);
      in_burst = rdy_seen[d] && (k[d] > 8 * IVL) && (k[d] < 9 * IVL);

      // R2: first request exactly after the pause
      if (!req_seen[d] && req[d]) begin
         chk(since_rst[d] == PAUSE, "R2", d, since_rst[d], PAUSE);
         req_seen[d] = 1'b1;
      end

      // R9: nothing happens on the strobes without a grant
      if (!gnt[d]) begin
         chk(ras[d] && cas[d] && !done[d], "R9", d,
             {29'd0, ras[d], cas[d], done[d]}, 6);
      end

      // R10: request only while idle
      if (req[d]) chk(ras[d] && cas[d], "R10", d, {30'd0, ras[d], cas[d]}, 3);

      // strobe shape accumulation
      if (!ras[d]) begin
         n_ras[d]++;
         if (!cas[d]) n_cas_act[d]++;
         if (d == 1) begin
            // R6: row sequence with wrap; R5: held while strobe low
            chk(int'(row[d]) == ref_idx[d] % ROWS, "R6", d, int'(row[d]), ref_idx[d] % ROWS);
         end else if (n_ras[d] == 1) begin
            chk(row[d] == '0, "R6", d, int'(row[d]), 0);
         end
      end else if (!cas[d]) begin
         if (n_ras[d] == 0) n_lead[d]++;
         else n_bad[d]++;
      end

      if (done[d]) begin
         chk(n_ras[d] == T_ACT, (d == 0) ? "R4" : "R5", d, n_ras[d], T_ACT);
         if (d == 0) begin
            chk(n_lead[d] == T_LEAD && n_cas_act[d] == T_ACT && n_bad[d] == 0, "R4", d,
                n_lead[d] * 100 + n_cas_act[d] * 10 + n_bad[d], T_LEAD * 100 + T_ACT * 10);
         end else begin
            chk(n_lead[d] + n_cas_act[d] + n_bad[d] == 0, "R5", d,
                n_lead[d] + n_cas_act[d] + n_bad[d], 0);
         end
         chk(ras[d] && cas[d], "R4", d, {30'd0, ras[d], cas[d]}, 3);
         n_ras[d] = 0; n_lead[d] = 0; n_cas_act[d] = 0; n_bad[d] = 0;
         ref_idx[d]++;
         if (!rdy_seen[d]) begin
            dummies[d]++;
         end else if (in_burst) begin
            burst[d]++;
         end else begin
            // R7: done lands on the interval grid
            chk(k[d] % IVL == len, "R7", d, k[d] % IVL, len);
         end
      end

      // R3: ready follows the dummy refreshes and stays
      if (rdy[d] && !rdy_seen[d]) begin
         chk(dummies[d] == DUMMY, "R3", d, dummies[d], DUMMY);
         rdy_seen[d] = 1'b1;
         k[d] = 0;
      end else if (rdy_seen[d] && !rdy[d]) begin
         chk(1'b0, "R3", d, 0, 1);
      end

      if (rdy_seen[d]) begin
         if (k[d] == 2 * IVL + len + 1) gnt[d] = 1'b0;
         // R8: debt is kept while the grant is withheld
         if (k[d] > 3 * IVL && k[d] < 8 * IVL) chk(req[d] == 1'b1, "R8", d, int'(req[d]), 1);
         if (k[d] == 8 * IVL) gnt[d] = 1'b1;
         if (k[d] == 9 * IVL - 1) chk(burst[d] == PMAX, "R8", d, burst[d], PMAX);
      end
   endtask

   initial begin
      int cyc;
      rst_n = 1'b0;
      for (int d = 0; d < 2; d++) begin
         gnt[d] = 1'b1; since_rst[d] = 0; k[d] = 0; req_seen[d] = 0; rdy_seen[d] = 0;
         dummies[d] = 0; ref_idx[d] = 0; n_ras[d] = 0; n_lead[d] = 0;
         n_cas_act[d] = 0; n_bad[d] = 0; burst[d] = 0;
      end
      repeat (3) @(negedge clk);
      for (int d = 0; d < 2; d++) begin
         // R1: reset state
         chk(!rdy[d] && !req[d] && !done[d] && ras[d] && cas[d], "R1", d,
             {27'd0, rdy[d], req[d], done[d], ras[d], cas[d]}, 3);
      end
      rst_n = 1'b1;
      cyc = 0;
      while (!(ref_idx[0] >= TARGET && ref_idx[1] >= TARGET)) begin
         @(posedge clk);
         cyc++;
         for (int d = 0; d < 2; d++) begin
            since_rst[d]++;
            if (rdy_seen[d]) k[d]++;
         end
         @(negedge clk);
         for (int d = 0; d < 2; d++) monitor(d);
         if (cyc > 150000) begin
            chk(1'b0, "watchdog", 0, cyc, 150000);
            break;
         end
      end
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

endmodule